// File: doc/BRIEF.md
# Expansion Bus Hold Arbiter

This block lets an outside agent borrow a shared external expansion bus from the local bus master. The outside agent raises an asynchronous hold request. The arbiter synchronises the request and stalls the local master so that no new transfer starts. It then waits until the master reports that no transfer is in flight. Only then does it turn off every output enable of the shared signal group. One cycle after the group has gone high impedance, it raises hold-acknowledge.

When the request is withdrawn, the arbiter drops hold-acknowledge. It turns the enables back on one cycle later and then lifts the stall. The order is fixed: tri-state before acknowledge, and un-acknowledge before re-drive. No bus driver can therefore overlap with the outside agent's drivers.

The shared group has `ADDR_W` byte-enable/low-address lines, an address strobe, a write/read direction line and a burst-last line. The pad drivers and the transaction engine sit outside the block. The arbiter only gates the master's values and enables on their way to the pads.

Top module: `xbus_hold_arb`

## Requirements
- R1: After reset, hold-acknowledge is low, stall is low, and every bus output enable follows the master's enable.
- R2: While the master reports busy, the bus stays driven and hold-acknowledge stays low, even with the request held high.
- R3: With the master idle, all bus output enables are off no more than 4 clock cycles after the request rises. The two synchroniser cycles are included in that count.
- R4: Hold-acknowledge rises no more than 2 cycles after the group has gone high impedance, and it is never high while any enable is on.
- R5: Hold-acknowledge falls no more than 4 cycles after the request falls.
- R6: The bus enables return no more than 2 cycles after hold-acknowledge falls, and never while it is high.
- R7: The group's bit layout is: bits [ADDR_W-1:0] carry byte-enable/low address, bit ADDR_W the strobe, bit ADDR_W+1 the direction and bit ADDR_W+2 the burst-last line. While the master owns the bus, each enable equals the master's enable. While the bus is released, all enables are zero.
- R8: Once the request has been taken in, dropping it before hold-acknowledge has risen does not abort the hand-over. Hold-acknowledge still rises, then falls again.
- R9: Stall is high from the cycle after the request is seen until the bus is driven again. It is always high while hold-acknowledge is high.
- R10: With the GATE_DATA option set (the default), every bus value reads zero while the bus is released. Otherwise the master's values pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_i | input | 1 | Asynchronous hold request from the outside agent |
| mst_busy_i | input | 1 | Local master has a transfer in flight or pending |
| mst_sig_i | input | ADDR_W+3 | Master's values for the shared group |
| mst_oe_i | input | ADDR_W+3 | Master's per-signal output enables |
| hold_ack_o | output | 1 | Hold-acknowledge to the outside agent |
| bus_sig_o | output | ADDR_W+3 | Values toward the pads |
| bus_oe_o | output | ADDR_W+3 | Per-signal output enables toward the pads |
| mst_stall_o | output | 1 | Blocks the master from starting new transfers |

## Verification
The assertions assume a well-behaved master: once stall is high it starts no new transfer, so busy only falls until the bus is reclaimed. They also assume the request, although asynchronous, stays steady long enough for the synchroniser to sample it. The bench drives the request and busy away from the clock edge and holds every request for several cycles. It never raises busy while stall is high, except for the one case that checks that busy alone keeps the bus driven. Only the glitch case drops the request before acknowledge, and it does so after the synchroniser has passed the request to the state machine.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

   // Step budgets of the handshake, counted in clock cycles
   localparam int unsigned RESP_BUDGET = 4;   // request edge -> tri-state / ack drop
   localparam int unsigned GAP_BUDGET  = 2;   // tri-state -> ack, ack drop -> re-drive

   // Cycles the state machine adds after the synchroniser (take-in + act)
   localparam int unsigned FSM_LATENCY = 2;

   typedef enum logic [1:0] {
      ST_OWN      = 2'd0,
      ST_DRAIN    = 2'd1,
      ST_RELEASED = 2'd2,
      ST_RECLAIM  = 2'd3
   } arb_state_t;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hold_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
   import hold_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_s_i,
   input  logic busy_i,
   output logic drive_o,
   output logic ack_o,
   output logic stall_o
);

   arb_state_t state_q;
   logic       drive_q;
   logic       ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OWN;
         drive_q <= 1'b1;
         ack_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_OWN: begin
               if (req_s_i) state_q <= ST_DRAIN;
            end
            ST_DRAIN: begin
               // committed: a request drop here is ignored
               if (!busy_i) begin
                  drive_q <= 1'b0;
                  state_q <= ST_RELEASED;
               end
            end
            ST_RELEASED: begin
               if (!ack_q) begin
                  ack_q <= 1'b1;
               end else if (!req_s_i) begin
                  ack_q   <= 1'b0;
                  state_q <= ST_RECLAIM;
               end
            end
            ST_RECLAIM: begin
               drive_q <= 1'b1;
               state_q <= ST_OWN;
            end
            default: state_q <= ST_OWN;
         endcase
      end
   end

   assign drive_o = drive_q;
   assign ack_o   = ack_q;
   assign stall_o = (state_q != ST_OWN);

   AST_DRAIN_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_q) |-> !$past(busy_i));                       // R2
   AST_ACK_ONLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> !drive_q);                                      // R4
   AST_ACK_AFTER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> $past(!drive_q));                        // R4
   AST_REDRIVE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_q) |=> drive_q);                                // R6
   AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN) |=> (state_q != ST_OWN));           // R8
   AST_STALL_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> stall_o);                                       // R9

endmodule

// File: rtl/bus_gate.sv
module bus_gate #(
   parameter int unsigned NSIG      = 7,
   parameter bit          GATE_DATA = 1'b1
) (
   input  logic            drive_i,
   input  logic [NSIG-1:0] sig_i,
   input  logic [NSIG-1:0] oe_i,
   output logic [NSIG-1:0] sig_o,
   output logic [NSIG-1:0] oe_o
);

   for (genvar i = 0; i < NSIG; i++) begin : g_line
      assign oe_o[i] = oe_i[i] & drive_i;
      if (GATE_DATA) begin : g_gated
         assign sig_o[i] = sig_i[i] & drive_i;
      end else begin : g_pass
         assign sig_o[i] = sig_i[i];
      end
   end

endmodule

// File: rtl/xbus_hold_arb.sv
module xbus_hold_arb
   import hold_arb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          GATE_DATA   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hold_req_i,
   input  logic                mst_busy_i,
   input  logic [ADDR_W+2:0]   mst_sig_i,
   input  logic [ADDR_W+2:0]   mst_oe_i,
   output logic                hold_ack_o,
   output logic [ADDR_W+2:0]   bus_sig_o,
   output logic [ADDR_W+2:0]   bus_oe_o,
   output logic                mst_stall_o
);

   localparam int unsigned NSIG = ADDR_W + 3;

   if (ADDR_W < 1) begin : g_bad_width
      $error("xbus_hold_arb: ADDR_W must be at least 1");
   end
   if (SYNC_STAGES + FSM_LATENCY > RESP_BUDGET) begin : g_bad_budget
      $error("xbus_hold_arb: synchroniser depth exceeds the response budget");
   end

   logic req_s;
   logic drive;

   hold_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (hold_req_i),
      .q_o   (req_s)
   );

   hold_fsm i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_s_i (req_s),
      .busy_i  (mst_busy_i),
      .drive_o (drive),
      .ack_o   (hold_ack_o),
      .stall_o (mst_stall_o)
   );

   bus_gate #(.NSIG(NSIG), .GATE_DATA(GATE_DATA)) i_gate (
      .drive_i (drive),
      .sig_i   (mst_sig_i),
      .oe_i    (mst_oe_i),
      .sig_o   (bus_sig_o),
      .oe_o    (bus_oe_o)
   );

   AST_GROUP_HIZ_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack_o |-> (bus_oe_o == '0));                         // R7
   AST_ACK_HOLDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mst_stall_o) |-> !hold_ack_o);                      // R9

   if (GATE_DATA) begin : g_gate_chk
      AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         hold_ack_o |-> (bus_sig_o == '0));                     // R10
   end

endmodule

// File: tb/test_xbus_hold_arb.sv
module test_xbus_hold_arb;

   localparam int ADDR_W = 4;
   localparam int SYNC   = 2;
   localparam int NSIG   = ADDR_W + 3;
   localparam logic [NSIG-1:0] ALL = '1;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            hold_req;
   logic            mst_busy;
   logic [NSIG-1:0] mst_sig;
   logic [NSIG-1:0] mst_oe;
   logic            hold_ack;
   logic [NSIG-1:0] bus_sig;
   logic [NSIG-1:0] bus_oe;
   logic            stall;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 0;

   always #4 clk = ~clk;   // 125 MHz

   xbus_hold_arb #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC), .GATE_DATA(1'b1)) i_xbus_hold_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_req_i  (hold_req),
      .mst_busy_i  (mst_busy),
      .mst_sig_i   (mst_sig),
      .mst_oe_i    (mst_oe),
      .hold_ack_o  (hold_ack),
      .bus_sig_o   (bus_sig),
      .bus_oe_o    (bus_oe),
      .mst_stall_o (stall)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit q_pipe[$];      // request samples, newest first
   int phase;          // 0 own, 1 draining, 2 released, 3 granted, 4 reclaiming
   bit m_drive;
   bit m_ack;

   initial begin
      for (int i = 0; i < SYNC; i++) q_pipe.push_back(1'b0);
      phase = 0; m_drive = 1; m_ack = 0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC; i++) q_pipe[i] = 1'b0;
         phase = 0; m_drive = 1; m_ack = 0;
      end else begin
         bit seen;
         seen = q_pipe[SYNC-1];
         case (phase)
            0: if (seen) phase = 1;
            1: if (!mst_busy) begin phase = 2; m_drive = 0; end
            2: begin phase = 3; m_ack = 1; end
            3: if (!seen) begin phase = 4; m_ack = 0; end
            default: begin phase = 0; m_drive = 1; end
         endcase
         q_pipe.push_front(hold_req);
         void'(q_pipe.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         logic [NSIG-1:0] e_oe, e_sig;
         e_oe  = m_drive ? mst_oe  : '0;
         e_sig = m_drive ? mst_sig : '0;
         check(hold_ack === m_ack, "R4 model ack", int'(hold_ack), int'(m_ack));
         check(bus_oe === e_oe, "R7 model bus_oe", int'(bus_oe), int'(e_oe));
         check(bus_sig === e_sig, "R10 model bus_sig", int'(bus_sig), int'(e_sig));
         check(stall === (phase != 0), "R9 model stall", int'(stall), int'(phase != 0));
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic handshake(input int hold_len, input logic [NSIG-1:0] oe, input logic [NSIG-1:0] sig);
      int n;
      mst_oe = oe; mst_sig = sig;
      hold_req = 1'b1;
      n = 0;
      while (bus_oe !== '0 && n < 20) begin @(negedge clk); n++; end
      check(n <= 4, "R3 cycles to tri-state", n, 4);
      n = 0;
      while (hold_ack !== 1'b1 && n < 20) begin @(negedge clk); n++; end
      check(n <= 2, "R4 cycles tri-state to ack", n, 2);
      check(stall === 1'b1, "R9 stall while granted", int'(stall), 1);
      check(bus_sig === '0, "R10 quiet bus while granted", int'(bus_sig), 0);
      repeat (hold_len) @(negedge clk);
      hold_req = 1'b0;
      n = 0;
      while (hold_ack !== 1'b0 && n < 20) begin @(negedge clk); n++; end
      check(n <= 4, "R5 cycles to ack drop", n, 4);
      n = 0;
      while (bus_oe !== oe && n < 20) begin @(negedge clk); n++; end
      check(n <= 2, "R6 cycles to re-drive", n, 2);
      @(negedge clk);
      check(stall === 1'b0, "R9 stall lifted", int'(stall), 0);
   endtask

   task automatic finish_up;
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      check(1'b0, "watchdog", 0, 1);
      finish_up();
   end

   initial begin
      int n;
      rst_n = 1'b0; hold_req = 1'b0; mst_busy = 1'b0;
      mst_oe = ALL; mst_sig = 7'h55;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(hold_ack === 1'b0, "R1 ack after reset", int'(hold_ack), 0);
      check(stall === 1'b0, "R1 stall after reset", int'(stall), 0);
      check(bus_oe === ALL, "R1 enables after reset", int'(bus_oe), int'(ALL));

      // R7 pass-through of enables per line while owning
      mst_oe = 7'b0101100; mst_sig = 7'h2a;
      @(negedge clk);
      check(bus_oe === 7'b0101100, "R7 enable layout", int'(bus_oe), 'h2c);
      check(bus_sig === 7'h2a, "R10 values pass while owning", int'(bus_sig), 'h2a);

      // basic hand-overs with varied patterns
      handshake(3, ALL, 7'h7f);
      handshake(0, 7'b1010011, 7'h13);
      handshake(6, ALL, 7'h40);

      // R2: busy master holds the bus
      mst_oe = ALL;
      mst_busy = 1'b1; hold_req = 1'b1;
      repeat (8) @(negedge clk);
      check(hold_ack === 1'b0, "R2 no ack while busy", int'(hold_ack), 0);
      check(bus_oe === ALL, "R2 bus driven while busy", int'(bus_oe), int'(ALL));
      check(stall === 1'b1, "R9 stall while draining", int'(stall), 1);
      mst_busy = 1'b0;
      n = 0;
      while (bus_oe !== '0 && n < 20) begin @(negedge clk); n++; end
      check(n <= 4, "R3 tri-state after drain", n, 4);
      repeat (3) @(negedge clk);
      hold_req = 1'b0;
      repeat (6) @(negedge clk);
      check(bus_oe === ALL, "R6 bus back after busy case", int'(bus_oe), int'(ALL));

      // R8: request dropped after take-in, before ack
      mst_busy = 1'b1; hold_req = 1'b1;
      repeat (3) @(negedge clk);
      hold_req = 1'b0;
      repeat (4) @(negedge clk);
      check(stall === 1'b1, "R8 hand-over kept after drop", int'(stall), 1);
      mst_busy = 1'b0;
      n = 0;
      while (hold_ack !== 1'b1 && n < 10) begin @(negedge clk); n++; end
      check(hold_ack === 1'b1, "R8 ack still rises", int'(hold_ack), 1);
      n = 0;
      while (bus_oe !== ALL && n < 10) begin @(negedge clk); n++; end
      check(bus_oe === ALL && hold_ack === 1'b0, "R8 bus reclaimed", int'(bus_oe), int'(ALL));

      // back-to-back with request re-raised immediately
      handshake(1, ALL, 7'h0f);
      handshake(2, 7'b1110000, 7'h70);
      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule